// File: doc/BRIEF.md
# SPI Transfer Suspend Gate

This block sits between the already-synchronised serial pins of an SPI slave and its command controller. It lets the host pause a transfer through an active-low suspend pin. While the pause lasts, serial clock edges and input data are dropped, so the controller's view of the bit stream freezes. The serial output enable is forced off, which leaves the data-out pin at high impedance. When the pause ends, the stream continues at the next bit.

The suspend pin is acted on only while the serial clock is low. A change of the pin made while the clock is high waits until the clock is low again. If chip select rises during a pause, the block issues a one-cycle abort strobe so the controller drops the whole command. The block also arms its edge detector only after it has seen the clock low inside the select window. A clock level that is already high when chip select falls is therefore never taken as a sampling edge.

Everything runs on one system clock. The clock edges seen on the serial clock input become one-cycle strobes on that system clock.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset `suspended`, `rxStb`, `txStb`, `abortStb` and `soOe` are all 0.
- R2: With `csN` low and the block not suspended, a serial clock rise yields one `rxStb` pulse one system cycle after the rise is sampled, with `rxBit` equal to `si` at that sample. A serial clock fall yields one `txStb` pulse with the same latency.
- R3: When `csN` is low and `sck` is low, `holdN` is sampled, and `suspended` equals the inverse of the sampled `holdN` from the next cycle on.
- R4: A change of `holdN` made while `sck` is high has no effect on `suspended` until `sck` has been sampled low.
- R5: While `suspended` is 1, no `rxStb` and no `txStb` pulses occur, whatever `sck` and `si` do.
- R6: `soOe` is 1 exactly when `soReq` is 1, `csN` is low and `suspended` is 0.
- R7: After a pause, the bits delivered continue the interrupted stream with no bit lost or repeated. A byte sent MSB first across a pause is delivered intact.
- R8: When `csN` rises while suspended, `abortStb` pulses for one cycle and `suspended` returns to 0. The next select window starts a fresh stream.
- R9: While `csN` is high, `holdN` has no effect: `suspended` stays 0 and no edge strobes occur.
- R10: A serial clock rise is not passed on unless `sck` has been sampled low after `csN` fell. This covers a rise that coincides with `csN` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock |
| si | input | 1 | Synchronised serial data in |
| holdN | input | 1 | Synchronised suspend request, active low |
| soReq | input | 1 | Controller wants to drive serial data out |
| rxStb | output | 1 | Qualified serial clock rise strobe |
| rxBit | output | 1 | Data bit captured at the qualified rise |
| txStb | output | 1 | Qualified serial clock fall strobe |
| abortStb | output | 1 | Command abort: chip select rose while suspended |
| soOe | output | 1 | Output enable for the serial data-out driver |
| suspended | output | 1 | Transfer is currently paused |

## Verification
The hardest situation to reach is a suspend request made while the serial clock is high, followed by a release also made while the clock is high. To reach it, the bench stops a bit half way, with the clock held high, and moves `holdN` there. It then lowers the clock and checks that the pause began exactly at that fall. A spurious clock pulse is given during the pause, and its closing fall must also be dropped. The coincident chip-select fall and clock rise is driven on a single system-clock edge, so the arming logic alone decides whether that rise is passed on.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Strobes handed from the control side to the datapath each cycle.
  typedef struct packed {
    logic rise;   // qualified serial clock rise
    logic fall;   // qualified serial clock fall
    logic abort;  // chip select rose during a pause
    logic held;   // pause state
  } gateStb_t;

  localparam int STB_W = $bits(gateStb_t);

endpackage

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sck,
  input  logic     holdN,
  output gateStb_t stb
);

  logic sckQ;    // serial clock one system cycle ago
  logic armed;   // clock seen low inside the current select window
  logic held;    // pause state

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ  <= 1'b0;
      armed <= 1'b0;
      held  <= 1'b0;
    end else begin
      sckQ <= sck;
      if (csN) begin
        armed <= 1'b0;
        held  <= 1'b0;
      end else if (!sck) begin
        armed <= 1'b1;
        held  <= !holdN;
      end
    end
  end

  logic edgeOk;
  assign edgeOk = armed && !held && !csN;

  always_comb begin
    stb       = '0;
    stb.rise  = sck && !sckQ && edgeOk;
    stb.fall  = !sck && sckQ && edgeOk;
    stb.abort = csN && held;
    stb.held  = held;
  end

  // R3/R4: pause state may only change inside a select window on a low clock
  assert_hold_change_sck_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csN) && (held != $past(held))) |-> !$past(sck));

  // R9: a deselected block is never paused
  assert_cs_high_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !held);

  // R10: no rise passes before the clock has been seen low after select
  assert_rise_needs_arm_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && !csN) |-> !stb.rise);

endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     si,
  input  logic     soReq,
  input  gateStb_t stb,
  output logic     rxStb,
  output logic     rxBit,
  output logic     txStb,
  output logic     abortStb,
  output logic     soOe,
  output logic     suspended
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStb    <= 1'b0;
      rxBit    <= 1'b0;
      txStb    <= 1'b0;
      abortStb <= 1'b0;
    end else begin
      rxStb    <= stb.rise;
      txStb    <= stb.fall;
      abortStb <= stb.abort;
      if (stb.rise) rxBit <= si;
    end
  end

  assign suspended = stb.held;
  assign soOe      = soReq && !csN && !stb.held;

  // R5: a paused stream emits no strobes on the following cycle
  assert_hold_blocks_strobes_R5: assert property (@(posedge clk) disable iff (!rstN)
    suspended |=> (!rxStb && !txStb));

  // R6: output driver off while paused or deselected
  assert_so_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (suspended || csN) |-> !soOe);

  // R8: abort follows a pause and clears it, and lasts one cycle
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortStb |-> (!suspended && $past(suspended)));
  assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortStb |=> !abortStb);

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic soReq,
  output logic rxStb,
  output logic rxBit,
  output logic txStb,
  output logic abortStb,
  output logic soOe,
  output logic suspended
);

  gateStb_t stb;

  spi_hold_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sck   (sck),
    .holdN (holdN),
    .stb   (stb)
  );

  spi_hold_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .si        (si),
    .soReq     (soReq),
    .stb       (stb),
    .rxStb     (rxStb),
    .rxBit     (rxBit),
    .txStb     (txStb),
    .abortStb  (abortStb),
    .soOe      (soOe),
    .suspended (suspended)
  );

endmodule

// File: tb/tb_spi_hold_gate.sv
module tb_spi_hold_gate;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, soReq = 1'b0;
  logic rxStb, rxBit, txStb, abortStb, soOe, suspended;

  int checks = 0, errors = 0;
  int rxCount = 0, txCount = 0, abortCount = 0;
  logic [15:0] rxShift = '0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_hold_gate dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .soReq(soReq), .rxStb(rxStb), .rxBit(rxBit), .txStb(txStb),
    .abortStb(abortStb), .soOe(soOe), .suspended(suspended)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rxStb) begin
        rxCount++;
        rxShift <= {rxShift[14:0], rxBit};
      end
      if (txStb) txCount++;
      if (abortStb) abortCount++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    si = b; tick(2);
    sck = 1'b1; tick(2);
    sck = 1'b0; tick(2);
  endtask

  task automatic endXfer();
    csN = 1'b1; soReq = 1'b0; holdN = 1'b1; tick(3);
  endtask

  task automatic testReset();
    tick(1);
    check(suspended === 1'b0 && rxStb === 1'b0 && txStb === 1'b0, "R1 strobes", {suspended, rxStb, txStb}, 0);
    check(abortStb === 1'b0 && soOe === 1'b0, "R1 abort/oe", {abortStb, soOe}, 0);
  endtask

  task automatic testPlain(input logic [7:0] val);
    int rx0, tx0;
    csN = 1'b0; soReq = 1'b1; tick(2);
    check(soOe === 1'b1, "R6 oe active", soOe, 1);
    rx0 = rxCount; tx0 = txCount;
    for (int i = 7; i >= 0; i--) sendBit(val[i]);
    check(rxCount - rx0 == 8, "R2 rise count", rxCount - rx0, 8);
    check(txCount - tx0 == 8, "R2 fall count", txCount - tx0, 8);
    check(rxShift[7:0] == val, "R2 data", rxShift[7:0], val);
    endXfer();
  endtask

  task automatic testHoldResume(input logic [7:0] val);
    int rx0, tx0, rxH, txH;
    csN = 1'b0; soReq = 1'b1; tick(2);
    rx0 = rxCount; tx0 = txCount;
    for (int i = 7; i >= 5; i--) sendBit(val[i]);
    holdN = 1'b0; tick(2);
    check(suspended === 1'b1, "R3 enter", suspended, 1);
    check(soOe === 1'b0, "R6 oe off held", soOe, 0);
    rxH = rxCount; txH = txCount;
    for (int k = 0; k < 3; k++) begin
      si = k[0]; sck = 1'b1; tick(2); sck = 1'b0; tick(2);
    end
    check(rxCount == rxH, "R5 no rise", rxCount - rxH, 0);
    check(txCount == txH, "R5 no fall", txCount - txH, 0);
    holdN = 1'b1; tick(2);
    check(suspended === 1'b0, "R3 release", suspended, 0);
    check(soOe === 1'b1, "R6 oe back", soOe, 1);
    for (int i = 4; i >= 0; i--) sendBit(val[i]);
    check(rxCount - rx0 == 8, "R7 count", rxCount - rx0, 8);
    check(rxShift[7:0] == val, "R7 data", rxShift[7:0], val);
    endXfer();
  endtask

  task automatic testDeferred(input logic [7:0] val);
    int rx0, tx0;
    csN = 1'b0; tick(2);
    rx0 = rxCount; tx0 = txCount;
    for (int i = 7; i >= 4; i--) sendBit(val[i]);
    si = val[3]; tick(2); sck = 1'b1; tick(2);
    holdN = 1'b0; tick(3);
    check(suspended === 1'b0, "R4 entry deferred", suspended, 0);
    sck = 1'b0; tick(2);
    check(suspended === 1'b1, "R4 entry at low", suspended, 1);
    si = ~val[2]; sck = 1'b1; tick(2);
    holdN = 1'b1; tick(3);
    check(suspended === 1'b1, "R4 release deferred", suspended, 1);
    sck = 1'b0; tick(2);
    check(suspended === 1'b0, "R4 release at low", suspended, 0);
    for (int i = 2; i >= 0; i--) sendBit(val[i]);
    check(rxCount - rx0 == 8, "R7 deferred count", rxCount - rx0, 8);
    check(txCount - tx0 == 8, "R5 deferred falls", txCount - tx0, 8);
    check(rxShift[7:0] == val, "R7 deferred data", rxShift[7:0], val);
    endXfer();
  endtask

  task automatic testAbort(input logic [7:0] val);
    int a0, rx0;
    csN = 1'b0; tick(2);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    holdN = 1'b0; tick(2);
    a0 = abortCount;
    csN = 1'b1; tick(3);
    check(abortCount - a0 == 1, "R8 abort pulse", abortCount - a0, 1);
    check(suspended === 1'b0, "R8 cleared", suspended, 0);
    holdN = 1'b1; tick(2);
    csN = 1'b0; tick(2);
    rx0 = rxCount;
    for (int i = 7; i >= 0; i--) sendBit(val[i]);
    check(rxCount - rx0 == 8 && rxShift[7:0] == val, "R8 fresh stream", rxShift[7:0], val);
    endXfer();
  endtask

  task automatic testIdle();
    int rx0, tx0;
    rx0 = rxCount; tx0 = txCount;
    holdN = 1'b0; tick(3);
    check(suspended === 1'b0, "R9 hold ignored", suspended, 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; tick(2); sck = 1'b0; tick(2);
    end
    check(rxCount == rx0 && txCount == tx0, "R9 no strobes", rxCount - rx0 + txCount - tx0, 0);
    holdN = 1'b1; tick(2);
  endtask

  task automatic testCsFallSckHigh(input logic [7:0] val);
    int rx0;
    rx0 = rxCount;
    si = 1'b1; csN = 1'b0; sck = 1'b1; tick(3);
    check(rxCount == rx0, "R10 coincident rise", rxCount - rx0, 0);
    sck = 1'b0; tick(2);
    for (int i = 7; i >= 0; i--) sendBit(val[i]);
    check(rxCount - rx0 == 8, "R10 count", rxCount - rx0, 8);
    check(rxShift[7:0] == val, "R10 data", rxShift[7:0], val);
    endXfer();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    testReset();
    tick(2);
    testPlain(8'hA5);
    testPlain(8'h3C);
    testHoldResume(8'hC9);
    testDeferred(8'h96);
    testAbort(8'h5A);
    testIdle();
    testCsFallSckHigh(8'h81);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule